// File: doc/BRIEF.md
# Rotate Unit with Carry

This block is the rotate slice of a processor's operand path. It takes a 32-bit operand and produces either the operand rotated right by a variable amount or the operand rotated right by one place through the carry flag. Along with the rotated value it produces the carry value that an instruction would write back, and a strobe that says whether carry is written at all. The unit has no clock and no state: every output follows its inputs within the same cycle, so it can sit directly between operand fetch and the ALU.

The caller chooses the operation with `op_ext`. When `op_ext` is 0 the unit performs a variable rotate. When `op_ext` is 1 it performs the one-place rotate through carry. The rotate amount is an 8-bit value taken straight from a register. Amounts above 32 wrap around, and an amount of exactly 32 is a full turn that still produces a carry. The caller raises `flag_en` only for instruction forms that update flags, which includes the test and logical forms that consume the rotated operand. When `flag_en` is low, the carry value passes through unchanged.

Top module: `rot_carry_unit`

## Requirements
- R1: With `op_ext`=0 and an amount n from 1 to 31, `result` is `opnd` rotated right by n places.
- R2: With `op_ext`=0, `flag_en`=1 and an amount n from 1 to 31, `carry_we` is 1 and `carry_out` equals bit n-1 of `opnd`.
- R3: With `op_ext`=0 and an amount of 0, `result` equals `opnd`, `carry_out` equals `carry_in` and `carry_we` is 0, whatever the value of `flag_en`.
- R4: With `op_ext`=0 and an amount of exactly 32, `result` equals `opnd`. When `flag_en`=1, `carry_out` equals `opnd[31]` and `carry_we` is 1.
- R5: With `op_ext`=0, any amount above 32 and up to 255 gives the same `result` and carry as that amount reduced by 32 until it is 32 or less (for example, 36 acts as 4, 64 acts as 32 and 255 acts as 31).
- R6: With `op_ext`=1, `result` is `{carry_in, opnd[31:1]}`.
- R7: With `op_ext`=1 and `flag_en`=1, `carry_out` equals `opnd[0]` and `carry_we` is 1.
- R8: With `flag_en`=0, `carry_we` is 0 and `carry_out` equals `carry_in` for both operations, and `result` is the same as it would be with `flag_en`=1.
- R9: All outputs settle from the current inputs alone, with no clock edge in between.
- R10: With `op_ext`=1, the value of `amt` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | 32 | Operand to rotate |
| amt | input | 8 | Rotate amount (0 to 255), used only when `op_ext`=0 |
| op_ext | input | 1 | 0 selects the variable rotate; 1 selects the one-place rotate through carry |
| carry_in | input | 1 | Current carry flag |
| flag_en | input | 1 | The instruction form updates flags |
| result | output | 32 | Rotated operand |
| carry_out | output | 1 | Carry value to write back |
| carry_we | output | 1 | Carry write strobe |

## Verification
The unit has no state, so any fault appears at the ports in the same cycle as the inputs that trigger it. A wrong stage in the rotate network corrupts `result` only for amounts that have the matching bit set. A wrong carry index shows up only as a `carry_out` mismatch when `flag_en` is high. The full sweep of amounts 0 to 255 over several operand patterns reaches every stage and every carry index. Directed vectors cover the full-turn case, the zero-amount case and the through-carry case, where the value of the carry pin itself changes the result.

// File: rtl/rot_carry_unit.sv
module rot_carry_unit #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic [W-1:0]  opnd,
  input  logic [AW-1:0] amt,
  input  logic          op_ext,
  input  logic          carry_in,
  input  logic          flag_en,
  output logic [W-1:0]  result,
  output logic          carry_out,
  output logic          carry_we
);
  localparam int LW = $clog2(W);
  localparam logic [LW-1:0] ONE = 1;

  logic [W-1:0]  stg [LW+1];
  logic [LW-1:0] cidx;
  logic          amt_nz;
  logic          rot_c;

  assign stg[0] = opnd;

  genvar k;
  generate
    for (k = 0; k < LW; k++) begin : g_stage
      localparam int S = 1 << k;
      assign stg[k+1] = amt[k] ? {stg[k][S-1:0], stg[k][W-1:S]} : stg[k];
    end
  endgenerate

  assign amt_nz = |amt;
  assign cidx   = amt[LW-1:0] - ONE;
  assign rot_c  = opnd[cidx];

  always_comb begin
    if (op_ext) begin
      result    = {carry_in, opnd[W-1:1]};
      carry_we  = flag_en;
      carry_out = flag_en ? opnd[0] : carry_in;
    end else begin
      result    = stg[LW];
      carry_we  = flag_en & amt_nz;
      carry_out = carry_we ? rot_c : carry_in;
    end
  end

  always_comb begin
    // R6
    ext_top_chk : assert (!op_ext || result[W-1] == carry_in)
      else $error("extend top bit differs from carry_in");
    // R7
    ext_carry_chk : assert (!(op_ext && flag_en) || carry_out == opnd[0])
      else $error("extend carry differs from opnd[0]");
    // R8
    no_flag_write_chk : assert (flag_en || (!carry_we && carry_out == carry_in))
      else $error("carry touched without flag_en");
    // R2
    rot_carry_chk : assert (op_ext || !carry_we || carry_out == result[W-1])
      else $error("rotate carry differs from result top bit");
    // R3
    zero_amt_chk : assert (op_ext || amt_nz || (result == opnd && !carry_we))
      else $error("zero amount changed the operand or wrote carry");
    // R1
    bit_count_chk : assert (op_ext || $countones(result) == $countones(opnd))
      else $error("rotate lost or gained bits");
  end
endmodule

// File: tb/sim_rot_carry_unit.sv
module sim_rot_carry_unit;
  logic        clk = 1'b0;
  logic [31:0] opnd;
  logic [7:0]  amt;
  logic        op_ext, carry_in, flag_en;
  logic [31:0] result;
  logic        carry_out, carry_we;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rot_carry_unit u0 (
    .opnd(opnd), .amt(amt), .op_ext(op_ext), .carry_in(carry_in),
    .flag_en(flag_en), .result(result), .carry_out(carry_out), .carry_we(carry_we)
  );

  localparam int NV = 9;
  localparam logic [31:0] V_OP  [NV] = '{32'h0000_0001, 32'h8000_0000, 32'h1234_5678,
    32'h0000_00F0, 32'h0000_0003, 32'h0000_0002, 32'h0000_0001, 32'hF000_0000, 32'h0000_0001};
  localparam logic [7:0]  V_AMT [NV] = '{8'd1, 8'd32, 8'd0, 8'd36, 8'd7, 8'd9, 8'd1, 8'd255, 8'd64};
  localparam logic        V_EXT [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic        V_CIN [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic        V_FEN [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [31:0] V_RES [NV] = '{32'h8000_0000, 32'h8000_0000, 32'h1234_5678,
    32'h0000_000F, 32'h8000_0001, 32'h0000_0001, 32'h8000_0000, 32'hE000_0001, 32'h0000_0001};
  localparam logic        V_C   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic        V_WE  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam string       V_TAG [NV] = '{"R1 R2", "R4", "R3", "R5", "R6 R7 R10",
    "R8", "R8", "R5", "R5 R4"};

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  task automatic ref_model(input logic [31:0] op, input int n_in, input logic ext,
                           input logic cin, input logic fen,
                           output logic [31:0] res, output logic c, output logic we);
    int n = n_in;
    logic [63:0] dbl;
    if (ext) begin
      res = {cin, op[31:1]};
      we  = fen;
      c   = fen ? op[0] : cin;
    end else begin
      while (n > 32) n -= 32;
      dbl = {op, op} >> n;
      res = (n == 0) ? op : dbl[31:0];
      we  = fen && (n != 0);
      c   = we ? op[n-1] : cin;
    end
  endtask

  task automatic apply(input logic [31:0] op, input logic [7:0] a, input logic ext,
                       input logic cin, input logic fen);
    @(negedge clk);
    opnd = op; amt = a; op_ext = ext; carry_in = cin; flag_en = fen;
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic ec, input logic ew);
    total++;
    if (result !== er || carry_out !== ec || carry_we !== ew) begin
      bad++;
      $display("FAIL %s: op=%h amt=%0d ext=%b got res=%h c=%b we=%b exp res=%h c=%b we=%b",
               tag, opnd, amt, op_ext, result, carry_out, carry_we, er, ec, ew);
    end
  endtask

  initial begin
    logic [31:0] er;
    logic ec, ew;
    logic [31:0] sweep_ops [4] = '{32'h8000_0001, 32'hA5C3_0F96, 32'h0000_0001, 32'h7FFF_FFFE};
    // idle inputs: all zero gives zero result and no carry write (R3)
    apply(32'h0, 8'd0, 1'b0, 1'b0, 1'b0);
    check("R3 idle", 32'h0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(V_OP[i], V_AMT[i], V_EXT[i], V_CIN[i], V_FEN[i]);
      check(V_TAG[i], V_RES[i], V_C[i], V_WE[i]);
    end

    // full sweep of amounts: R1 R2 R3 R4 R5 R8
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 256; a++) begin
        for (int f = 0; f < 2; f++) begin
          ref_model(sweep_ops[s], a, 1'b0, a[0] ^ s[0], f[0], er, ec, ew);
          apply(sweep_ops[s], a[7:0], 1'b0, a[0] ^ s[0], f[0]);
          check("R1 R2 R5 sweep", er, ec, ew);
        end
      end
    end

    // amt ignored by the extend operation: R10 R6 R7
    for (int a = 0; a < 256; a += 17) begin
      ref_model(32'h5A5A_5A5B, 0, 1'b1, a[1], 1'b1, er, ec, ew);
      apply(32'h5A5A_5A5B, a[7:0], 1'b1, a[1], 1'b1);
      check("R10 extend", er, ec, ew);
    end

    // R9: outputs follow a change with no clock edge in between
    @(negedge clk);
    opnd = 32'h0000_0010; amt = 8'd4; op_ext = 1'b0; carry_in = 1'b0; flag_en = 1'b1;
    #1;
    check("R9 comb a", 32'h0000_0001, 1'b0, 1'b1);
    amt = 8'd5;
    #1;
    check("R9 comb b", 32'h8000_0000, 1'b1, 1'b1);

    finish_run();
  end
endmodule